// File: doc/BRIEF.md
# Dual-Rate O-QPSK Frame Spreader

This block is the chip sequencer on the transmit side of a sub-GHz O-QPSK physical layer. It accepts a frame as a stream of bytes over a valid/ready handshake. The frame is made of preamble bytes, a start-of-frame delimiter, a length byte, and then the payload. The block turns each byte into two 4-bit symbols and each symbol into a run of chips, one chip per clock. The chip rate therefore stays the same across the whole frame.

The header (preamble, delimiter and length byte) is always spread with the full 16-chip code. This keeps synchronisation robust. The payload can instead use a code shortened to 8 chips (two-fold rate) or to 4 chips (four-fold rate), which doubles or quadruples the payload data rate. In the four-fold mode, a 15-bit chip scrambler can whiten the payload chips. The chip-rate select picks one of two code families, one for the 400 kchip/s setting and one for the 1000 kchip/s setting. The code tables are placeholders computed from simple formulas; they are not the standard tables.

The length byte tells the block how many payload bytes follow. The block ends the frame by itself after the last chip of the last byte and flags that chip.

Top module: `oqpsk_dual_rate_spreader`

## Requirements
- R1: The first PRE_BYTES+2 bytes of a frame (default 6: four preamble bytes, the delimiter and the length byte) are each spread as two symbols of 16 chips. Symbol s of family f uses the code word W with W[i] = B16f[(i - 2*(s mod 8)) mod 16] XOR s[3], where B16 is 16'h3A6E for family 0 and 16'hC5B1 for family 1.
- R2: With rate_sel = 01, each payload symbol is spread to 8 chips, W[i] = B8f[(i - (s mod 8)) mod 8] XOR s[3], where B8 is 8'h1D for family 0 and 8'hB2 for family 1.
- R3: With rate_sel = 10 or 11, each payload symbol is spread to 4 chips, W = s XOR B4f, where B4 is 4'h6 for family 0 and 4'h9 for family 1.
- R4: With rate_sel = 00, payload symbols use the same 16-chip code as the header.
- R5: chip_rate_sel picks the code family (0 or 1). Exactly one chip is emitted per clock, and chip_valid stays high without gaps through a frame while the source keeps in_valid high.
- R6: Within a byte, the low nibble is sent before the high nibble. Within a symbol, code bit 0 is sent first. A change of code length happens only at the first chip of a symbol.
- R7: In the four-fold mode with scram_en = 1, each payload chip is XORed with f = L[14] XOR L[13] of a 15-bit register L. L is set to 15'h7FFF at the start of each payload, and after each payload chip it shifts to {L[13:0], f}. Header chips are never scrambled.
- R8: In the basic and two-fold modes, scram_en has no effect on the chips. In the four-fold mode, scram_en = 0 sends the payload chips unscrambled.
- R9: Bits 6:0 of the length byte give the payload byte count N (0 to 127); bit 7 is ignored. The frame ends after exactly N payload bytes. With N = 0, the frame ends after the length byte.
- R10: frame_done is high only together with the last chip of a frame, and chip_valid is low in the cycle after it.
- R11: chip_rate_sel, rate_sel and scram_en are sampled when the first byte of a frame is accepted. Changes to them during the frame have no effect on that frame.
- R12: in_ready is high when no byte is held, and also on the last chip of a byte that is not the frame's last byte; it is low at all other times. After reset, in_ready = 1, chip_valid = 0 and frame_done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_rate_sel | input | 1 | Code family select (0: 400 kchip/s, 1: 1000 kchip/s) |
| rate_sel | input | 2 | Payload spreading: 00 full, 01 half, 1x quarter |
| scram_en | input | 1 | Enables payload chip scrambling in the quarter mode |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte taken on this edge when in_valid is high |
| chip_out | output | 1 | Serial chip |
| chip_valid | output | 1 | chip_out carries a chip |
| frame_done | output | 1 | Marks the last chip of the frame |

## Verification
The bench sweeps both code families, all four rate_sel codes and both scram_en values, with payload lengths from 0 to 4 bytes and one long scrambled frame. Taken together, these frames separate the header code from the payload code, the half code from the quarter code, and a scrambled quarter payload from a plain one. Half of the length bytes carry bit 7 set, and the frames mix idle gaps with back-to-back starts. After each frame's first byte, the bench inverts every setting input, so any setting that is not latched shows up as a wrong chip. Every chip is compared with a stream computed from the code formulas. In the same pass, the ready and done flags are compared on every cycle.

// File: rtl/oqpsk_spr_pkg.sv
package oqpsk_spr_pkg;

    typedef enum logic [1:0] {
        SPR_FULL    = 2'b00,
        SPR_HALF    = 2'b01,
        SPR_QUARTER = 2'b10
    } spr_len_e;

    localparam logic [15:0] FULL_BASE_F0 = 16'h3A6E;
    localparam logic [15:0] FULL_BASE_F1 = 16'hC5B1;
    localparam logic [7:0]  HALF_BASE_F0 = 8'h1D;
    localparam logic [7:0]  HALF_BASE_F1 = 8'hB2;
    localparam logic [3:0]  QTR_BASE_F0  = 4'h6;
    localparam logic [3:0]  QTR_BASE_F1  = 4'h9;
    localparam logic [14:0] SCR_SEED     = 15'h7FFF;

    function automatic spr_len_e rate_to_len(input logic [1:0] r);
        if (r[1])      return SPR_QUARTER;
        else if (r[0]) return SPR_HALF;
        else           return SPR_FULL;
    endfunction

    function automatic logic [15:0] rotl16(input logic [15:0] x, input logic [3:0] k);
        logic [31:0] w;
        w = {x, x} << k;
        return w[31:16];
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input logic [2:0] k);
        logic [15:0] w;
        w = {x, x} << k;
        return w[15:8];
    endfunction

endpackage

// File: rtl/oqpsk_code_gen.sv
module oqpsk_code_gen
    import oqpsk_spr_pkg::*;
(
    input  logic [3:0]  sym,
    input  logic        fam,
    input  spr_len_e    len_sel,
    output logic [15:0] code,
    output logic [3:0]  last_idx
);
    logic [15:0] full_base;
    logic [7:0]  half_base;
    logic [3:0]  qtr_base;

    always_comb begin
        full_base = fam ? FULL_BASE_F1 : FULL_BASE_F0;
        half_base = fam ? HALF_BASE_F1 : HALF_BASE_F0;
        qtr_base  = fam ? QTR_BASE_F1  : QTR_BASE_F0;
        unique case (len_sel)
            SPR_HALF: begin
                code     = {8'h00, rotl8(half_base, sym[2:0]) ^ {8{sym[3]}}};
                last_idx = 4'd7;
            end
            SPR_QUARTER: begin
                code     = {12'h000, sym ^ qtr_base};
                last_idx = 4'd3;
            end
            default: begin
                code     = rotl16(full_base, {sym[2:0], 1'b0}) ^ {16{sym[3]}};
                last_idx = 4'd15;
            end
        endcase
    end
endmodule

// File: rtl/oqpsk_chip_scrambler.sv
module oqpsk_chip_scrambler
    import oqpsk_spr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reseed,
    input  logic        advance,
    output logic        scr_bit,
    output logic [14:0] scr_state
);
    logic [14:0] lfsr_d, lfsr_q;

    assign scr_bit   = lfsr_q[14] ^ lfsr_q[13];
    assign scr_state = lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (reseed)       lfsr_d = SCR_SEED;
        else if (advance) lfsr_d = {lfsr_q[13:0], scr_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SCR_SEED;
        else        lfsr_q <= lfsr_d;
    end
endmodule

// File: rtl/oqpsk_dual_rate_spreader.sv
module oqpsk_dual_rate_spreader
    import oqpsk_spr_pkg::*;
#(
    parameter int PRE_BYTES = 4,
    parameter int LEN_W     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_rate_sel,
    input  logic [1:0] rate_sel,
    input  logic       scram_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       chip_out,
    output logic       chip_valid,
    output logic       frame_done
);
    localparam int HDR_BYTES = PRE_BYTES + 2;
    localparam int HDR_W     = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        logic             have;
        logic [7:0]       byte_v;
        logic             psdu;
        logic             last;
        logic             half;
        logic [3:0]       chip;
        logic             in_frame;
        logic [HDR_W-1:0] hdr;
        logic [LEN_W-1:0] rem;
        logic             fam;
        spr_len_e         len_e;
        logic             scr_on;
    } st_t;

    st_t q, d;

    logic [3:0]  sym;
    spr_len_e    len_sel;
    logic [15:0] code;
    logic [3:0]  last_idx;
    logic        sym_end, byte_end, load, scr_active, scr_bit, reseed;
    logic [14:0] scr_state;
    logic        frame_active_w, cur_psdu_w;
    logic [1:0]  cfg_len_w;

    assign sym     = q.half ? q.byte_v[7:4] : q.byte_v[3:0];
    assign len_sel = q.psdu ? q.len_e : SPR_FULL;

    oqpsk_code_gen u_code (
        .sym      (sym),
        .fam      (q.fam),
        .len_sel  (len_sel),
        .code     (code),
        .last_idx (last_idx)
    );

    assign sym_end    = q.have && (q.chip == last_idx);
    assign byte_end   = sym_end && q.half;
    assign in_ready   = !q.have || (byte_end && !q.last);
    assign load       = in_valid && in_ready;
    assign scr_active = q.have && q.psdu && q.scr_on;
    assign reseed     = load && !(q.in_frame && (q.hdr == HDR_W'(HDR_BYTES)));

    oqpsk_chip_scrambler u_scr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reseed    (reseed),
        .advance   (scr_active),
        .scr_bit   (scr_bit),
        .scr_state (scr_state)
    );

    assign chip_out   = q.have & (code[q.chip] ^ (scr_active & scr_bit));
    assign chip_valid = q.have;
    assign frame_done = byte_end && q.last;

    assign frame_active_w = q.in_frame;
    assign cur_psdu_w     = q.psdu;
    assign cfg_len_w      = q.len_e;

    always_comb begin
        d = q;
        if (q.have) begin
            if (sym_end) begin
                d.chip = 4'd0;
                d.half = ~q.half;
                if (q.half) begin
                    d.have = 1'b0;
                    if (q.last) d.in_frame = 1'b0;
                end
            end else begin
                d.chip = q.chip + 4'd1;
            end
        end
        if (load) begin
            d.have   = 1'b1;
            d.byte_v = in_data;
            d.half   = 1'b0;
            d.chip   = 4'd0;
            if (!q.in_frame) begin
                d.in_frame = 1'b1;
                d.fam      = chip_rate_sel;
                d.len_e    = rate_to_len(rate_sel);
                d.scr_on   = scram_en && (rate_to_len(rate_sel) == SPR_QUARTER);
                d.psdu     = 1'b0;
                d.last     = 1'b0;
                d.hdr      = HDR_W'(1);
            end else if (q.hdr != HDR_W'(HDR_BYTES)) begin
                d.psdu = 1'b0;
                d.hdr  = q.hdr + HDR_W'(1);
                if (q.hdr == HDR_W'(HDR_BYTES - 1)) begin
                    d.rem  = in_data[LEN_W-1:0];
                    d.last = (in_data[LEN_W-1:0] == '0);
                end else begin
                    d.last = 1'b0;
                end
            end else begin
                d.psdu = 1'b1;
                d.rem  = q.rem - LEN_W'(1);
                d.last = (q.rem == LEN_W'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.len_e  <= SPR_FULL;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/oqpsk_spr_checker.sv
module oqpsk_spr_checker
    import oqpsk_spr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        chip_valid,
    input logic        frame_done,
    input logic        frame_active,
    input logic        cur_psdu,
    input logic [14:0] scr_state,
    input logic [1:0]  cfg_len
);
    // R10
    a_r10_done_has_chip: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> chip_valid);
    // R10
    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !chip_valid);
    // R12
    a_r12_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid |-> in_ready);
    // R12
    a_r12_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !in_ready);
    // R11
    a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && $past(frame_active)) |-> $stable(cfg_len));
    // R7
    a_r7_hdr_seeded: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !cur_psdu) |-> (scr_state == SCR_SEED));
    // R9
    a_r9_chip_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> frame_active);
endmodule

bind oqpsk_dual_rate_spreader oqpsk_spr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .chip_valid   (chip_valid),
    .frame_done   (frame_done),
    .frame_active (frame_active_w),
    .cur_psdu     (cur_psdu_w),
    .scr_state    (scr_state),
    .cfg_len      (cfg_len_w)
);

// File: tb/sim_oqpsk_dual_rate_spreader.sv
module sim_oqpsk_dual_rate_spreader;
    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam int HDR        = PRE + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_rate_sel = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       scram_en = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, chip_out, chip_valid, frame_done;

    oqpsk_dual_rate_spreader #(.PRE_BYTES(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .chip_rate_sel(chip_rate_sel), .rate_sel(rate_sel),
        .scram_en(scram_en), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .chip_out(chip_out), .chip_valid(chip_valid), .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    in_burst = 0;
    bit    finished = 0;
    bit    e_chip[$];
    bit    e_done[$];
    bit    e_rdy[$];
    string e_tag[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit bit16(input int s, input bit fam, input int i);
        logic [15:0] b;
        b = fam ? 16'hC5B1 : 16'h3A6E;
        return b[((i - 2 * (s % 8)) % 16 + 16) % 16] ^ s[3];
    endfunction

    function automatic bit bit8(input int s, input bit fam, input int i);
        logic [7:0] b;
        b = fam ? 8'hB2 : 8'h1D;
        return b[((i - (s % 8)) % 8 + 8) % 8] ^ s[3];
    endfunction

    function automatic bit bit4(input int s, input bit fam, input int i);
        logic [3:0] w;
        w = 4'(s) ^ (fam ? 4'h9 : 4'h6);
        return w[i];
    endfunction

    // Expected chip stream for one frame, from the requirements
    task automatic build(input bit fam, input logic [1:0] rs, input bit scr,
                         input logic [7:0] hb[$]);
        logic [14:0] lf;
        int          nb, clen, mode;
        bit          psdu, v, fb;
        string       tag;
        nb = hb.size();
        lf = 15'h7FFF;
        mode = rs[1] ? 4 : (rs[0] ? 2 : 1);
        for (int b = 0; b < nb; b++) begin
            psdu = (b >= HDR);
            clen = psdu ? 16 / mode : 16;
            if (!psdu)          tag = "R1 R5 R6";
            else if (mode == 4) tag = scr ? "R7 R3 R11" : "R8 R3 R11";
            else if (mode == 2) tag = scr ? "R8 R2 R11" : "R2 R11";
            else                tag = scr ? "R8 R4 R11" : "R4 R11";
            for (int h = 0; h < 2; h++) begin
                int s;
                s = h ? int'(hb[b][7:4]) : int'(hb[b][3:0]);
                for (int c = 0; c < clen; c++) begin
                    if (clen == 16)     v = bit16(s, fam, c);
                    else if (clen == 8) v = bit8(s, fam, c);
                    else                v = bit4(s, fam, c);
                    if (psdu && mode == 4 && scr) begin
                        fb = lf[14] ^ lf[13];
                        v  = v ^ fb;
                        lf = {lf[13:0], fb};
                    end
                    e_chip.push_back(v);
                    e_done.push_back(b == nb - 1 && h == 1 && c == clen - 1);
                    e_rdy.push_back(b != nb - 1 && h == 1 && c == clen - 1);
                    e_tag.push_back(tag);
                end
            end
        end
    endtask

    // Monitor: every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (chip_valid) begin
                if (e_chip.size() == 0) begin
                    chk(0, "R9 unexpected chip", 1, 0);
                end else begin
                    bit    xc, xd, xr;
                    string t;
                    xc = e_chip.pop_front();
                    xd = e_done.pop_front();
                    xr = e_rdy.pop_front();
                    t  = e_tag.pop_front();
                    chk(chip_out == xc, {t, " chip"}, int'(chip_out), int'(xc));
                    chk(frame_done == xd, "R10 R9 done", int'(frame_done), int'(xd));
                    chk(in_ready == xr, "R12 ready", int'(in_ready), int'(xr));
                    in_burst = !xd;
                end
            end else begin
                if (in_burst) chk(0, "R5 gap in chip stream", 0, 1);
                if (frame_done || !in_ready)
                    chk(0, "R12 R10 idle flags", int'({frame_done, in_ready}), 1);
                in_burst = 0;
            end
        end
    end

    task automatic send(input logic [7:0] hb[$], input bit fam, input logic [1:0] rs,
                        input bit scr);
        bit acc;
        for (int b = 0; b < hb.size(); b++) begin
            @(negedge clk);
            if (b == 0) begin
                chip_rate_sel = fam; rate_sel = rs; scram_en = scr;
            end else if (b == 1) begin
                chip_rate_sel = ~fam; rate_sel = ~rs; scram_en = ~scr; // R11
            end
            in_valid = 1'b1;
            in_data  = hb[b];
            forever begin
                acc = in_ready;
                @(posedge clk);
                if (acc) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic frame(input bit fam, input logic [1:0] rs, input bit scr,
                         input logic [7:0] phr, input int seed, input int gap);
        logic [7:0] hb[$];
        hb = {};
        for (int i = 0; i < PRE; i++) hb.push_back(8'h00);
        hb.push_back(8'hA7);
        hb.push_back(phr);
        for (int k = 0; k < int'(phr[6:0]); k++) hb.push_back(8'((seed * 29 + k * 53 + 7) & 255));
        build(fam, rs, scr, hb);
        send(hb, fam, rs, scr);
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1,   "R12 reset in_ready", int'(in_ready), 1);
        chk(chip_valid == 1'b0, "R12 reset chip_valid", int'(chip_valid), 0);
        chk(frame_done == 1'b0, "R12 reset frame_done", int'(frame_done), 0);
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 4; r++)
                for (int s = 0; s < 2; s++) begin
                    int idx;
                    logic [7:0] phr;
                    idx = f * 8 + r * 2 + s;
                    phr = 8'(idx % 5) | (idx[0] ? 8'h80 : 8'h00); // R9 bit 7 ignored
                    frame(f[0], 2'(r), s[0], phr, idx, idx % 3);
                end
        frame(1'b0, 2'b10, 1'b1, 8'd20, 99, 2);  // R7 long scrambled payload
        frame(1'b1, 2'b11, 1'b1, 8'd12, 55, 0);  // R3 code 11 as quarter
        frame(1'b0, 2'b01, 1'b1, 8'h00, 3, 1);   // R9 empty payload
        repeat (40) @(negedge clk);
        chk(e_chip.size() == 0, "R9 chips missing", e_chip.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule